// File: doc/BRIEF.md
# Halfword-Granular Instruction Prefetch Buffer

This block sits between a word-wide instruction memory and the decode stage of a core that mixes 16-bit and 32-bit instructions. It sends word-aligned fetch requests over a request/grant/response port and keeps up to four fetched words in a small queue. It hands decode one aligned instruction at a time, together with its halfword-granular PC and a flag that marks a 16-bit instruction.

Each instruction starts at the halfword the PC points to. If that halfword is a 16-bit instruction, the block issues it as soon as the word that holds it has arrived. If a 32-bit instruction starts in the upper half of a word, the block joins that half with the lower half of the following word. A redirect input (taken branch or jump) flushes the queue and restarts fetching at the target. Responses that belong to requests granted before the redirect are thrown away when they arrive.

Top module: `halfword_prefetch_buf`

## Requirements
- R1: While reset is held, instr_valid_o is 0, and mem_req_o is 1 with mem_addr_o equal to BOOT_ADDR (0 by default).
- R2: Every address on mem_addr_o has bits [1:0] equal to 0. Each granted request is 4 above the previous granted one, unless a redirect came in between.
- R3: A halfword whose bits [1:0] are not 2'b11 is a 16-bit instruction. It is output as {16'h0000, halfword} with instr_is_c_o = 1.
- R4: A 32-bit instruction at a PC with bit 1 = 0 is output as the full word at that address, with instr_is_c_o = 0.
- R5: A 32-bit instruction at a PC with bit 1 = 1 is output as {lower half of the next word, upper half of the current word}. It is not valid until both words are buffered.
- R6: A 16-bit instruction in the lower half of a word is valid once that single word has arrived, without waiting for the next word.
- R7: Buffered words plus live requests (granted and not yet answered, excluding stale ones) never exceed four. After a redirect with decode stalled and memory always granting, exactly four requests are granted.
- R8: In a cycle with redir_i = 1, instr_valid_o is 0 and no handshake takes place. All buffered words are discarded.
- R9: After a redirect the PC is the target with bit 0 cleared, and the first request is the target with bits [1:0] cleared. If target bit 1 is set, the lower halfword of that first word is skipped.
- R10: A response to a request granted in or before the redirect cycle is dropped. The first instruction delivered after a redirect has instr_pc_o equal to the target.
- R11: While instr_valid_o = 1 and instr_ready_i = 0, instr_o and instr_pc_o hold their values in the next cycle unless a redirect occurs.
- R12: On each handshake the PC advances by 2 for a 16-bit instruction and by 4 for a 32-bit one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redir_i | input | 1 | Taken branch or jump: flush and restart |
| redir_addr_i | input | AW | Redirect target, halfword granular |
| mem_req_o | output | 1 | Fetch request |
| mem_addr_o | output | AW | Word-aligned fetch address |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Response data valid |
| mem_rdata_i | input | 32 | Response word |
| instr_valid_o | output | 1 | Instruction available for decode |
| instr_ready_i | input | 1 | Decode accepts the instruction |
| instr_o | output | 32 | Aligned instruction, 16-bit ones zero-extended |
| instr_pc_o | output | AW | PC of the instruction |
| instr_is_c_o | output | 1 | Instruction is 16 bits |

## Verification
The memory model answers one cycle after each grant. A word pushed on a response edge shows up on the output combinationally just after that edge, so output checks are made at the falling edge that follows. Decode-side outputs depend combinationally on redir_i. For that reason every cycle drives its inputs at the falling edge and samples one nanosecond later, while the same cycle's handshake or redirect is still pending. A reference walk over a halfword pattern computed in the bench predicts every delivered instruction and PC, and every granted address. Directed sequences limit grants to one word at a time, to time the single-word release of 16-bit instructions, the two-word wait of straddling ones, and the four-request capacity.

// File: rtl/pfb_pkg.sv
`timescale 1ns/1ps
package pfb_pkg;
  typedef logic [31:0] word_t;
  typedef logic [15:0] half_t;

  function automatic logic is_short(input half_t h);
    return h[1:0] != 2'b11;
  endfunction
endpackage

// File: rtl/pfb_word_fifo.sv
`timescale 1ns/1ps
module pfb_word_fifo
  import pfb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  word_t         wdata_i,
  input  logic          pop_i,
  output word_t         head_o,
  output half_t         next_lo_o,
  output logic [CW-1:0] fill_o
);
  localparam int PW = $clog2(DEPTH);

  word_t         mem_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, rd_nxt;
  logic [CW-1:0] fill;

  assign rd_nxt    = rd_ptr + 1'b1;
  assign head_o    = mem_q[rd_ptr];
  assign next_lo_o = mem_q[rd_nxt][15:0];
  assign fill_o    = fill;

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_i) wr_ptr <= wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= rd_nxt;
      fill <= fill + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/pfb_fetch_ctrl.sv
`timescale 1ns/1ps
module pfb_fetch_ctrl #(
  parameter int            AW        = 32,
  parameter int            DEPTH     = 4,
  parameter int            CW        = $clog2(DEPTH + 1),
  parameter logic [AW-1:0] BOOT_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          redir_i,
  input  logic [AW-1:0] redir_addr_i,
  input  logic [CW-1:0] fill_i,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          push_o,
  output logic [CW-1:0] live_o
);
  localparam logic [CW:0]   DEPTH_X = (CW+1)'(DEPTH);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] WMASK   = ~AW'(3);

  logic [AW-1:0] fetch_addr;
  logic [CW-1:0] inflight, drop, inflight_n;
  logic          gnt_ok;

  assign live_o     = inflight - drop;
  // space counts buffered words plus live requests; inflight cap bounds stale backlog
  assign mem_req_o  = (inflight < DEPTH_C) &&
                      (({1'b0, fill_i} + {1'b0, live_o}) < DEPTH_X);
  assign mem_addr_o = fetch_addr;
  assign gnt_ok     = mem_req_o && mem_gnt_i;
  assign push_o     = mem_rvalid_i && (drop == '0) && !redir_i;
  assign inflight_n = inflight + CW'(gnt_ok) - CW'(mem_rvalid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_addr <= BOOT_ADDR & WMASK;
      inflight   <= '0;
      drop       <= '0;
    end else begin
      inflight <= inflight_n;
      if (redir_i) begin
        fetch_addr <= redir_addr_i & WMASK;
        drop       <= inflight_n;
      end else begin
        if (gnt_ok) fetch_addr <= fetch_addr + AW'(4);
        if (mem_rvalid_i && drop != '0) drop <= drop - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfb_align.sv
`timescale 1ns/1ps
module pfb_align
  import pfb_pkg::*;
#(
  parameter int CW = 3
) (
  input  word_t         head_i,
  input  half_t         next_lo_i,
  input  logic [CW-1:0] fill_i,
  input  logic          upper_i,
  output logic          avail_o,
  output word_t         instr_o,
  output logic          is_c_o,
  output logic          pop_o
);
  half_t sel;

  always_comb begin
    sel    = upper_i ? head_i[31:16] : head_i[15:0];
    is_c_o = is_short(sel);
    if (is_c_o)       instr_o = {16'h0000, sel};
    else if (upper_i) instr_o = {next_lo_i, head_i[31:16]};
    else              instr_o = head_i;
    avail_o = (fill_i != '0) && (is_c_o || !upper_i || fill_i >= CW'(2));
    // head word is finished when the instruction ends at or beyond its top
    pop_o   = upper_i || !is_c_o;
  end
endmodule

// File: rtl/halfword_prefetch_buf.sv
`timescale 1ns/1ps
module halfword_prefetch_buf
  import pfb_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DEPTH     = 4,
  parameter logic [AW-1:0] BOOT_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          redir_i,
  input  logic [AW-1:0] redir_addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          instr_valid_o,
  input  logic          instr_ready_i,
  output logic [31:0]   instr_o,
  output logic [AW-1:0] instr_pc_o,
  output logic          instr_is_c_o
);
  localparam int            CW    = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] HMASK = ~AW'(1);

  logic [AW-1:0] pc;
  logic [CW-1:0] fill, live;
  logic          push, avail, pop_need, accept;
  word_t         head;
  half_t         next_lo;

  assign accept        = instr_valid_o && instr_ready_i;
  assign instr_valid_o = avail && !redir_i;
  assign instr_pc_o    = pc;

  pfb_fetch_ctrl #(.AW(AW), .DEPTH(DEPTH), .CW(CW), .BOOT_ADDR(BOOT_ADDR)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .redir_i      (redir_i),
    .redir_addr_i (redir_addr_i),
    .fill_i       (fill),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .push_o       (push),
    .live_o       (live)
  );

  pfb_word_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (redir_i),
    .push_i    (push),
    .wdata_i   (mem_rdata_i),
    .pop_i     (accept && pop_need),
    .head_o    (head),
    .next_lo_o (next_lo),
    .fill_o    (fill)
  );

  pfb_align #(.CW(CW)) u_align (
    .head_i    (head),
    .next_lo_i (next_lo),
    .fill_i    (fill),
    .upper_i   (pc[1]),
    .avail_o   (avail),
    .instr_o   (instr_o),
    .is_c_o    (instr_is_c_o),
    .pop_o     (pop_need)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc <= BOOT_ADDR & HMASK;
    else if (redir_i) pc <= redir_addr_i & HMASK;
    else if (accept)  pc <= pc + (instr_is_c_o ? AW'(2) : AW'(4));
  end
endmodule

// File: rtl/pfb_checker.sv
`timescale 1ns/1ps
module pfb_checker #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          redir_i,
  input logic [AW-1:0] redir_addr_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          instr_valid_o,
  input logic          instr_ready_i,
  input logic [31:0]   instr_o,
  input logic [AW-1:0] instr_pc_o,
  input logic          instr_is_c_o,
  input logic [CW-1:0] fill,
  input logic [CW-1:0] live
);
  a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  a_r3_short_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && instr_is_c_o) |-> (instr_o[31:16] == 16'h0 && instr_o[1:0] != 2'b11));

  a_r5_two_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && !instr_is_c_o && instr_pc_o[1]) |-> fill >= CW'(2));

  a_r7_capacity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, fill} + {1'b0, live}) <= (CW+1)'(DEPTH));

  a_r8_quiet_on_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |-> !instr_valid_o);

  a_r9_pc_on_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> instr_pc_o == ($past(redir_addr_i) & ~AW'(1)));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && !instr_ready_i) |=>
      (redir_i || (instr_valid_o && $stable(instr_o) && $stable(instr_pc_o))));

  a_r12_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && instr_ready_i) |=>
      instr_pc_o == $past(instr_pc_o) + ($past(instr_is_c_o) ? AW'(2) : AW'(4)));
endmodule

bind halfword_prefetch_buf pfb_checker #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .redir_i       (redir_i),
  .redir_addr_i  (redir_addr_i),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .instr_valid_o (instr_valid_o),
  .instr_ready_i (instr_ready_i),
  .instr_o       (instr_o),
  .instr_pc_o    (instr_pc_o),
  .instr_is_c_o  (instr_is_c_o),
  .fill          (fill),
  .live          (live)
);

// File: tb/halfword_prefetch_buf_test.sv
`timescale 1ns/1ps
module halfword_prefetch_buf_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        redir_i = 1'b0;
  logic [31:0] redir_addr_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_gnt_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        instr_valid_o;
  logic        instr_ready_i = 1'b0;
  logic [31:0] instr_o;
  logic [31:0] instr_pc_o;
  logic        instr_is_c_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  halfword_prefetch_buf uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .redir_i(redir_i), .redir_addr_i(redir_addr_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .instr_valid_o(instr_valid_o), .instr_ready_i(instr_ready_i), .instr_o(instr_o),
    .instr_pc_o(instr_pc_o), .instr_is_c_o(instr_is_c_o)
  );

  function automatic logic [15:0] hw_at(input logic [31:0] i);
    logic [15:0] v;
    v = 16'(i * 32'd40503 + 32'd17);
    if ((((i * 3) ^ (i >> 1)) & 32'd3) != 0) v[1:0] = 2'b11;
    else v[1:0] = 2'(i % 3);
    return v;
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {hw_at((a >> 1) + 1), hw_at(a >> 1)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bench state
  logic [15:0] lfsr = 16'hace1;
  int          gnt_mode = 0, rdy_mode = 0, grants_left = 0, gcount = 0, cyc = 0;
  bit          pend_v = 0, redir_req = 0, after_redir = 0;
  logic [31:0] pend_a = '0, redir_tgt = '0, exp_next = '0, mpc = '0;
  bit          prev_stall = 0;
  logic [31:0] prev_instr = '0, prev_pc = '0;

  task automatic step();
    logic [15:0] h;
    logic [31:0] exp_i;
    bit          exp_c;
    @(negedge clk_i);
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rvalid_i = pend_v;
    mem_rdata_i  = pend_v ? word_at(pend_a) : 32'hdead_beef;
    pend_v       = 0;
    redir_i      = redir_req;
    redir_addr_i = redir_tgt;
    case (rdy_mode)
      0: instr_ready_i = 1'b1;
      1: instr_ready_i = lfsr[3];
      2: instr_ready_i = (cyc % 3) == 0;
      default: instr_ready_i = 1'b0;
    endcase
    case (gnt_mode)
      0: mem_gnt_i = 1'b1;
      1: mem_gnt_i = lfsr[7];
      2: mem_gnt_i = (cyc % 3) != 1;
      default: mem_gnt_i = grants_left > 0;
    endcase
    #1;
    if (mem_req_o && mem_gnt_i) begin
      pend_v = 1;
      pend_a = mem_addr_o;
      gcount++;
      if (grants_left > 0) grants_left--;
      chk(mem_addr_o == exp_next, "R2 granted address sequence", mem_addr_o, exp_next);
      exp_next = mem_addr_o + 4;
    end
    if (redir_i) begin
      chk(!instr_valid_o, "R8 valid low in redirect cycle", {31'b0, instr_valid_o}, 32'd0);
      exp_next    = redir_tgt & ~32'd3;
      mpc         = redir_tgt & ~32'd1;
      after_redir = 1;
      prev_stall  = 0;
    end else begin
      if (prev_stall)
        chk(instr_valid_o && instr_o == prev_instr && instr_pc_o == prev_pc,
            "R11 output held while stalled", instr_o, prev_instr);
      if (instr_valid_o) begin
        h = hw_at(mpc >> 1);
        exp_c = (h[1:0] != 2'b11);
        exp_i = exp_c ? {16'h0, h} : {hw_at((mpc >> 1) + 1), h};
        if (after_redir)
          chk(instr_pc_o == mpc, "R10 first pc after redirect", instr_pc_o, mpc);
        else
          chk(instr_pc_o == mpc, "R12 pc progression", instr_pc_o, mpc);
        after_redir = 0;
        if (exp_c)
          chk(instr_o == exp_i && instr_is_c_o, "R3 short instruction", instr_o, exp_i);
        else if (!mpc[1])
          chk(instr_o == exp_i && !instr_is_c_o, "R4 aligned long instruction", instr_o, exp_i);
        else
          chk(instr_o == exp_i && !instr_is_c_o, "R5 straddling long instruction", instr_o, exp_i);
        if (instr_ready_i) mpc = mpc + (exp_c ? 32'd2 : 32'd4);
      end
      prev_stall = instr_valid_o && !instr_ready_i;
      prev_instr = instr_o;
      prev_pc    = instr_pc_o;
    end
    redir_req = 0;
  endtask

  task automatic redirect_to(input logic [31:0] t);
    redir_req = 1;
    redir_tgt = t;
    step();
  endtask

  initial begin
    logic [31:0] t6, t5;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    #1;
    chk(!instr_valid_o, "R1 valid low in reset", {31'b0, instr_valid_o}, 32'd0);
    chk(mem_req_o, "R1 request in reset", {31'b0, mem_req_o}, 32'd1);
    chk(mem_addr_o == 32'd0, "R1 boot address", mem_addr_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // sweep of grant and ready patterns with periodic redirects
    for (int g = 0; g < 3; g++) begin
      for (int r = 0; r < 3; r++) begin
        gnt_mode = g;
        rdy_mode = r;
        for (int k = 0; k < 400; k++) begin
          if (k % 53 == 52) redirect_to(32'((cyc * 32'd2654435761) >> 8) & 32'h0000_3ffe);
          else step();
        end
      end
    end

    // R6: short instruction in lower half released from a single word
    t6 = 32'd400;
    while (!(hw_at(t6) [1:0] != 2'b11)) t6 += 2;
    t6 = t6 * 2;
    gnt_mode = 3; grants_left = 0; rdy_mode = 3;
    redirect_to(t6);
    grants_left = 1;
    repeat (6) step();
    chk(instr_valid_o && instr_is_c_o && instr_pc_o == t6, "R6 short issued from one word",
        {instr_valid_o, instr_is_c_o, instr_pc_o[29:0]}, {2'b11, t6[29:0]});

    // R5/R9: long instruction at upper half waits for the second word
    t5 = 32'd601;
    while (hw_at(t5) [1:0] != 2'b11) t5 += 2;
    redirect_to(t5 * 2);
    grants_left = 1;
    repeat (6) step();
    chk(!instr_valid_o, "R5 wait for second word", {31'b0, instr_valid_o}, 32'd0);
    grants_left = 1;
    repeat (4) step();
    chk(instr_valid_o && instr_o == {hw_at(t5 + 1), hw_at(t5)}, "R9 upper-half target assembled",
        instr_o, {hw_at(t5 + 1), hw_at(t5)});

    // R7: capacity with decode stalled
    gnt_mode = 0;
    redirect_to(32'h0000_1000);
    gcount = 0;
    repeat (20) step();
    chk(gcount == 4, "R7 grants while stalled", 32'(gcount), 32'd4);

    // R10: resume after a redirect with a grant outstanding
    rdy_mode = 0;
    repeat (3) step();
    redirect_to(32'h0000_0802);
    repeat (300) step();
    gnt_mode = 1; rdy_mode = 1;
    repeat (300) step();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule